// File: doc/BRIEF.md
# Triggered Descriptor-Chain DMA Sequencer

This block is a single-channel DMA engine that starts on a hardware trigger pulse. It walks a fixed, looping chain of transfer descriptors and moves data over a simple memory-mapped bus that has no wait states. Each run ends with a one-cycle completion pulse. Every internal phase has a fixed cycle cost, so the time from trigger to completion is known in advance. The last descriptor links back to the first, so the next trigger runs the whole chain again with no software involvement.

The built-in chain has three descriptors:
- A one-word move that copies a status word into a control location.
- A one-word move that copies a result word into a buffer.
- A two-element byte loop that pulls bytes 1 and 3 out of that buffered word and packs them into the low two bytes of an output word.

A trigger that arrives during a run is held for one more run. Any further triggers in that run are counted as overruns. The cycle count of the most recent run is available as an output.

Top module: `dma_chain_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `bus_rd` and `bus_wr` are low, and `last_lat` and `ovr_cnt` are zero.
- R2: With no trigger pending and no run in progress, the block issues no bus read, no bus write and no `done`.
- R3: Phase costs are fixed: preparation 6 cycles, one-word descriptor load 4, loop descriptor load 5, pointer load 1 per element, transfer 3 per element. With the default chain, `done` is first high in the cycle after the 35th rising edge that follows the edge which sampled the trigger.
- R4: Descriptor 0 copies the 32-bit word at the status address (0x0010) to the control address (0x0020).
- R5: Descriptor 1 copies the 32-bit word at the result address (0x0030) to the buffer address (0x0100).
- R6: Descriptor 2 writes buffer byte 1 into byte 0 of the output word (0x0200) and buffer byte 3 into byte 1 of that word. Each byte is written with a single byte enable, so bytes 2 and 3 of the output word keep their previous value.
- R7: `done` is high for exactly one clock per completed run.
- R8: Each element is one bus read followed two cycles later by one bus write, so a default run issues exactly 4 reads and 4 writes. `bus_rd` and `bus_wr` are never high together.
- R9: Every later trigger reruns the whole chain with the same latency, reading the current source contents.
- R10: One trigger that arrives while a run is busy is latched. The next run starts on the edge after the one that raised `done`, so its `done` comes 36 cycles after the previous one.
- R11: Each trigger that arrives while busy with a trigger already latched adds 1 to `ovr_cnt`.
- R12: `last_lat` holds the cycle count of the most recent run (35 by default). It updates in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start request pulse |
| bus_rd | output | 1 | Bus read strobe, one cycle |
| bus_wr | output | 1 | Bus write strobe, one cycle |
| bus_addr | output | 16 | Byte address for the read or write |
| bus_be | output | 4 | Byte enables for the write |
| bus_wdata | output | 32 | Write data, byte lanes replicated for byte moves |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_rd` |
| done | output | 1 | One-cycle end-of-chain pulse |
| busy | output | 1 | A run is in progress |
| last_lat | output | 8 | Cycle count of the most recent run |
| ovr_cnt | output | 8 | Number of triggers dropped as overruns |

## Verification
The hardest state to reach from the ports is a trigger that lands mid-run while another trigger is already latched. That case is the only way `ovr_cnt` moves, and it also decides when the follow-on run starts. The bench drives the first trigger and then injects further one-cycle trigger pulses at chosen cycle offsets inside the 35-cycle run. From those offsets it predicts the cycle of the second `done` and the overrun total. The main sweep varies the status and result words across many patterns, so that the byte-lane extraction and the untouched upper bytes are checked for each one.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned AW      = 16;
  localparam int unsigned DW      = 32;
  localparam int unsigned LANES   = DW / 8;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned STEP_W  = 3;
  localparam int unsigned XFER_CYC = 3;  // read issue, data return, write issue

  typedef enum logic [2:0] {PH_IDLE, PH_PREP, PH_LOAD, PH_PTR, PH_XFER} phase_e;

  typedef struct packed {
    logic              loop;   // 1: multi-element loop descriptor
    logic              wide;   // 1: word elements, 0: byte elements
    logic [AW-1:0]     src;
    logic [AW-1:0]     dst;
    logic [CNT_W-1:0]  cnt;
    logic [STEP_W-1:0] sstep;
    logic [STEP_W-1:0] dstep;
    logic [IDX_W-1:0]  nxt;
  } desc_t;
endpackage

// File: rtl/dma_desc_rom.sv
module dma_desc_rom
  import dma_chain_pkg::*;
#(
  parameter int unsigned   DEPTH  = 4,
  parameter logic [AW-1:0] STAT_A = 16'h0010,
  parameter logic [AW-1:0] CTRL_A = 16'h0020,
  parameter logic [AW-1:0] RES_A  = 16'h0030,
  parameter logic [AW-1:0] BUF_A  = 16'h0100,
  parameter logic [AW-1:0] OUT_A  = 16'h0200
) (
  input  logic [IDX_W-1:0] rd_idx,
  output desc_t            rd_desc
);
  desc_t tbl [DEPTH];

  function automatic desc_t entry(input int unsigned i);
    desc_t d;
    d = '0;
    case (i)
      1: begin
        d.wide = 1'b1; d.src = RES_A; d.dst = BUF_A;
        d.cnt = CNT_W'(1); d.nxt = IDX_W'(2);
      end
      2: begin
        d.loop = 1'b1; d.src = BUF_A + AW'(1); d.dst = OUT_A;
        d.cnt = CNT_W'(2); d.sstep = STEP_W'(2); d.dstep = STEP_W'(1);
        d.nxt = IDX_W'(0);
      end
      default: begin
        d.wide = 1'b1; d.src = STAT_A; d.dst = CTRL_A;
        d.cnt = CNT_W'(1); d.nxt = (i == 0) ? IDX_W'(1) : IDX_W'(0);
      end
    endcase
    return d;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = entry(g);
  end

  assign rd_desc = tbl[rd_idx];
endmodule

// File: rtl/dma_lane.sv
module dma_lane
  import dma_chain_pkg::*;
(
  input  logic              wide,
  input  logic [LANE_W-1:0] src_lo,
  input  logic [LANE_W-1:0] dst_lo,
  input  logic [DW-1:0]     rdata,
  output logic [DW-1:0]     wdata,
  output logic [LANES-1:0]  be
);
  logic [7:0] pick;

  always_comb begin
    pick = rdata[8*src_lo +: 8];
    if (wide) begin
      wdata = rdata;
      be    = '1;
    end else begin
      wdata = {LANES{pick}};
      be    = LANES'(1) << dst_lo;
    end
  end
endmodule

// File: rtl/dma_trig_track.sv
module dma_trig_track #(
  parameter int unsigned LAT_W = 8,
  parameter int unsigned OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             start,
  input  logic             running,
  input  logic             finish,
  output logic             pend,
  output logic [LAT_W-1:0] last_lat,
  output logic [OVR_W-1:0] ovr_cnt
);
  logic [LAT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      run_cnt  <= '0;
      last_lat <= '0;
      ovr_cnt  <= '0;
    end else begin
      if (start)
        pend <= 1'b0;
      else if (trig && running) begin
        if (!pend) pend <= 1'b1;
        else       ovr_cnt <= ovr_cnt + 1'b1;
      end
      if (start)        run_cnt <= '0;
      else if (running) run_cnt <= run_cnt + 1'b1;
      if (finish) last_lat <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int unsigned PREP_CYC = 6,
  parameter int unsigned LD1_CYC  = 4,
  parameter int unsigned LDX_CYC  = 5,
  parameter int unsigned PTR_CYC  = 1,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned LAT_W    = 8,
  parameter int unsigned OVR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [15:0]      bus_addr,
  output logic [3:0]       bus_be,
  output logic [31:0]      bus_wdata,
  input  logic [31:0]      bus_rdata,
  output logic             done,
  output logic             busy,
  output logic [LAT_W-1:0] last_lat,
  output logic [OVR_W-1:0] ovr_cnt
);
  localparam int unsigned PH_W = $clog2(PREP_CYC + LD1_CYC + LDX_CYC + PTR_CYC + XFER_CYC);

  phase_e            state;
  logic [PH_W-1:0]   ph_cnt;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  nxt_q;
  logic              wide_q;
  logic [STEP_W-1:0] sstep_q, dstep_q;
  logic [AW-1:0]     src_p, dst_p;
  logic [CNT_W-1:0]  elem_left;
  logic [IDX_W-1:0]  rom_idx;
  desc_t             rom_q;
  logic [DW-1:0]     lane_wdata;
  logic [LANES-1:0]  lane_be;
  logic              pend, start, finish;

  function automatic logic [PH_W-1:0] ld_cost(input logic is_loop);
    return is_loop ? PH_W'(LDX_CYC - 1) : PH_W'(LD1_CYC - 1);
  endfunction

  assign rom_idx = (state == PH_XFER) ? nxt_q : idx;
  assign start   = (state == PH_IDLE) && (trig || pend);
  assign finish  = (state == PH_XFER) && (ph_cnt == '0) &&
                   (elem_left <= CNT_W'(1)) && (nxt_q == '0);

  dma_desc_rom #(.DEPTH(DEPTH)) u_rom (.rd_idx(rom_idx), .rd_desc(rom_q));

  dma_lane u_lane (
    .wide(wide_q), .src_lo(src_p[LANE_W-1:0]), .dst_lo(dst_p[LANE_W-1:0]),
    .rdata(bus_rdata), .wdata(lane_wdata), .be(lane_be)
  );

  dma_trig_track #(.LAT_W(LAT_W), .OVR_W(OVR_W)) u_track (
    .clk(clk), .rst(rst), .trig(trig), .start(start), .running(busy),
    .finish(finish), .pend(pend), .last_lat(last_lat), .ovr_cnt(ovr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE; ph_cnt <= '0; idx <= '0; nxt_q <= '0;
      wide_q <= 1'b0; sstep_q <= '0; dstep_q <= '0;
      src_p <= '0; dst_p <= '0; elem_left <= '0;
      bus_rd <= 1'b0; bus_wr <= 1'b0; bus_addr <= '0; bus_be <= '0;
      bus_wdata <= '0; done <= 1'b0; busy <= 1'b0;
    end else begin
      done   <= 1'b0;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
      unique case (state)
        PH_IDLE: if (start) begin
          state <= PH_PREP; ph_cnt <= PH_W'(PREP_CYC - 1); idx <= '0; busy <= 1'b1;
        end
        PH_PREP: if (ph_cnt == '0) begin
          state <= PH_LOAD; ph_cnt <= ld_cost(rom_q.loop);
        end else ph_cnt <= ph_cnt - 1'b1;
        PH_LOAD: if (ph_cnt == '0) begin
          wide_q <= rom_q.wide; sstep_q <= rom_q.sstep; dstep_q <= rom_q.dstep;
          nxt_q <= rom_q.nxt; src_p <= rom_q.src; dst_p <= rom_q.dst;
          elem_left <= rom_q.cnt;
          state <= PH_PTR; ph_cnt <= PH_W'(PTR_CYC - 1);
        end else ph_cnt <= ph_cnt - 1'b1;
        PH_PTR: if (ph_cnt == '0) begin
          state <= PH_XFER; ph_cnt <= PH_W'(XFER_CYC - 1);
          bus_rd <= 1'b1; bus_addr <= src_p;
        end else ph_cnt <= ph_cnt - 1'b1;
        PH_XFER: begin
          if (ph_cnt == PH_W'(1)) begin
            bus_wr <= 1'b1; bus_addr <= dst_p;
            bus_wdata <= lane_wdata; bus_be <= lane_be;
          end
          if (ph_cnt == '0) begin
            src_p <= src_p + AW'(sstep_q);
            dst_p <= dst_p + AW'(dstep_q);
            elem_left <= elem_left - 1'b1;
            if (elem_left > CNT_W'(1)) begin
              state <= PH_PTR; ph_cnt <= PH_W'(PTR_CYC - 1);
            end else if (finish) begin
              state <= PH_IDLE; done <= 1'b1; busy <= 1'b0;
            end else begin
              state <= PH_LOAD; idx <= nxt_q; ph_cnt <= ld_cost(rom_q.loop);
            end
          end else ph_cnt <= ph_cnt - 1'b1;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int unsigned PREP_CYC = 6,
  parameter int unsigned LD1_CYC  = 4,
  parameter int unsigned LDX_CYC  = 5,
  parameter int unsigned PTR_CYC  = 1,
  parameter int unsigned LAT_W    = 8,
  parameter int unsigned OVR_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             done,
  input logic             busy,
  input logic [LAT_W-1:0] last_lat,
  input logic [OVR_W-1:0] ovr_cnt
);
  localparam int unsigned EXP_LAT = PREP_CYC + 2 * (LD1_CYC + PTR_CYC + 3) + LDX_CYC + 2 * (PTR_CYC + 3);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r8_wr_after_rd: assert property (@(posedge clk) disable iff (rst) bus_wr |-> $past(bus_rd, 2));
  a_r8_no_overlap:  assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr));
  a_r2_idle_quiet:  assert property (@(posedge clk) disable iff (rst) !busy |-> !bus_rd && !bus_wr);
  a_r11_ovr_step:   assert property (@(posedge clk) disable iff (rst)
                      (ovr_cnt != $past(ovr_cnt)) |-> (ovr_cnt == $past(ovr_cnt) + 1'b1));
  a_r12_lat_on_done: assert property (@(posedge clk) disable iff (rst) done |-> last_lat == LAT_W'(EXP_LAT));
  a_r3_done_ends_run: assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy));
endmodule

bind dma_chain_seq dma_chain_seq_chk #(
  .PREP_CYC(PREP_CYC), .LD1_CYC(LD1_CYC), .LDX_CYC(LDX_CYC), .PTR_CYC(PTR_CYC),
  .LAT_W(LAT_W), .OVR_W(OVR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .done(done),
  .busy(busy), .last_lat(last_lat), .ovr_cnt(ovr_cnt)
);

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic        bus_rd, bus_wr, done, busy;
  logic [15:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [7:0]  last_lat, ovr_cnt;
  logic [31:0] mem [256];

  int checks = 0;
  int errors = 0;

  localparam int STAT_I = 16'h0010 >> 2;
  localparam int CTRL_I = 16'h0020 >> 2;
  localparam int RES_I  = 16'h0030 >> 2;
  localparam int BUF_I  = 16'h0100 >> 2;
  localparam int OUT_I  = 16'h0200 >> 2;

  always #2.5 clk = ~clk;

  dma_chain_seq uut (
    .clk(clk), .rst(rst), .trig(trig), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .busy(busy),
    .last_lat(last_lat), .ovr_cnt(ovr_cnt)
  );

  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= mem[bus_addr[9:2]];
    if (bus_wr)
      for (int b = 0; b < 4; b++)
        if (bus_be[b]) mem[bus_addr[9:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_watch(input int p1, input int p2, input int p3, input int limit,
                           output int d1, output int d2, output int dn,
                           output int rds, output int wrs);
    d1 = -1; d2 = -1; dn = 0; rds = 0; wrs = 0;
    @(negedge clk); trig = 1'b1;
    for (int k = 0; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if (bus_rd) rds++;
      if (bus_wr) wrs++;
      if (done) begin
        dn++;
        if (d1 < 0) d1 = k; else if (d2 < 0) d2 = k;
      end
      trig = (k == p1 || k == p2 || k == p3);
    end
    trig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d1, d2, dn, rds, wrs, quiet;
    logic [31:0] st, rs, fill;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !bus_rd && !bus_wr, "R1 ctrl outputs", {busy, done, bus_rd, bus_wr}, 0);
    check(last_lat == 0 && ovr_cnt == 0, "R1 counters", {last_lat, ovr_cnt}, 0);
    // R2 idle with no trigger
    quiet = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (bus_rd || bus_wr || done) quiet++;
    end
    check(quiet == 0, "R2 idle activity", quiet, 0);

    // Sweep of data patterns; each run is a fresh retrigger (R9)
    for (int i = 0; i < 16; i++) begin
      st   = (i * 32'h01030507) ^ 32'h5AC3_0F11;
      rs   = (i * 32'h11223344) ^ 32'hA5F0_7E19 ^ (32'h1 << i);
      fill = 32'hC0DE_0000 | i;
      mem[STAT_I] = st; mem[RES_I] = rs; mem[OUT_I] = fill;
      run_watch(-1, -1, -1, 50, d1, d2, dn, rds, wrs);
      check(d1 == 35, "R3 R9 latency", d1, 35);
      check(dn == 1, "R7 done width", dn, 1);
      check(rds == 4 && wrs == 4, "R8 bus counts", {rds[15:0], wrs[15:0]}, {16'd4, 16'd4});
      check(mem[CTRL_I] == st, "R4 status copy", mem[CTRL_I], st);
      check(mem[BUF_I] == rs, "R5 result copy", mem[BUF_I], rs);
      check(mem[OUT_I] == {fill[31:16], rs[31:24], rs[15:8]}, "R6 byte extract",
            mem[OUT_I], {fill[31:16], rs[31:24], rs[15:8]});
      check(last_lat == 35, "R12 last latency", last_lat, 35);
      check(!busy, "R9 rearmed idle", busy, 0);
    end

    // One trigger mid-run: latched, follow-on run (R10)
    mem[STAT_I] = 32'h1234_5678;
    run_watch(10, -1, -1, 90, d1, d2, dn, rds, wrs);
    check(d1 == 35, "R10 first done", d1, 35);
    check(d2 == 71, "R10 second done", d2, 71);
    check(rds == 8 && wrs == 8, "R10 bus counts", {rds[15:0], wrs[15:0]}, {16'd8, 16'd8});
    check(ovr_cnt == 0, "R11 no overrun yet", ovr_cnt, 0);
    check(last_lat == 35, "R12 after rerun", last_lat, 35);

    // Three triggers mid-run: one latched, two overruns (R11)
    run_watch(5, 10, 15, 90, d1, d2, dn, rds, wrs);
    check(d2 == 71, "R10 latched rerun", d2, 71);
    check(ovr_cnt == 2, "R11 overrun count", ovr_cnt, 2);
    check(dn == 2, "R7 two pulses", dn, 2);

    // Trigger during the final cycle of a run is still latched (R10)
    run_watch(34, -1, -1, 90, d1, d2, dn, rds, wrs);
    check(d1 == 35 && d2 == 71, "R10 late trigger", {d1[15:0], d2[15:0]}, {16'd35, 16'd71});
    check(ovr_cnt == 2, "R11 unchanged", ovr_cnt, 2);

    // R2 quiet afterwards
    quiet = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bus_rd || bus_wr || done || busy) quiet++;
    end
    check(quiet == 0, "R2 final idle", quiet, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule